// File: doc/BRIEF.md
# Compensation Step-Response Bitstream Checker

This block runs a short digital test on an open-loop amplifier whose two offset-injection switches it controls. After a start request it steps those two controls through a fixed sequence of five states. Every state is held for a programmable number of clock cycles. At the end of each state it samples the amplifier's digitized output, which it first passes through a two-stage synchronizer. It then compares the five samples against the pattern a healthy amplifier gives.

The step period is chosen shorter than the extra settling delay that a healthy compensation network adds. With that period, an amplifier whose compensation is open slews quickly enough to show a wrong level in some step. The output in the first step depends on the amplifier's own offset, so that step is never compared.

When the run ends, the block holds three results until the next start: a fail flag, the index of the first step that mismatched, and the five captured samples.

Top module: `comp_step_checker`

## Requirements
- R1: After reset both drive outputs, `busy`, `done` and `fail` are 0, `captured` is 0 and `first_fail_idx` is 7.
- R2: A start accepted at a clock edge sets `busy` and begins step 0 at that edge. The drive pair {drv_neg, drv_pos} takes the values 00, 01, 00, 10, 11 for steps 0 to 4, and each step lasts exactly `period_cycles` clocks.
- R3: The amplifier input passes through two flops. `captured[k]` holds the synchronized level seen on the last cycle of step k (bit k is step k).
- R4: The expected levels for steps 1 to 4 are 1, 1, 0, 0, and step 0 is never compared. `fail` is 1 after a run exactly when a compared step mismatched.
- R5: `first_fail_idx` is the lowest step number that mismatched, or 7 when none did.
- R6: Exactly 5×`period_cycles` clocks after the start edge, `busy` falls, `done` rises and both drives return to 00. `done` and all results hold until the next start.
- R7: A start pulse while `busy` is high is ignored, including its period value.
- R8: A `period_cycles` value of 0 is treated as 1.
- R9: An accepted start clears `done`, `fail`, `captured` and `first_fail_idx` (to 7) before the new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| period_cycles | input | CNT_W | Step length in clocks, latched at start |
| amp_level | input | 1 | Digitized amplifier output, asynchronous |
| drv_neg | output | 1 | Negative offset-injection control |
| drv_pos | output | 1 | Positive offset-injection control |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| fail | output | 1 | At least one compared step mismatched |
| first_fail_idx | output | 3 | Lowest failing step, 7 if none |
| captured | output | 5 | Sampled level per step, bit k is step k |

## Verification
The assertions assume reset is applied at the start and `start` is a single-cycle pulse. They check the drive, busy and done relations and the coherence of the fail results; they make no assumption about when the amplifier level moves. The bench changes the amplifier level only at step boundaries and uses periods of at least three clocks in result-checking runs, so the synchronizer delay never hides a level. The one zero-period run checks only timing.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NSTEP  = 5;
  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] NO_FAIL_IDX = 3'd7;
  // Expected healthy level per step (bit k = step k) and which steps are compared
  localparam logic [NSTEP-1:0] EXP_LEVEL = 5'b00110;
  localparam logic [NSTEP-1:0] CARE_MASK = 5'b11110;

  typedef struct packed {
    logic neg;
    logic pos;
  } drive_t;

  function automatic drive_t drive_for(input logic [STEP_W-1:0] step);
    drive_t d;
    case (step)
      3'd1:    d = '{neg: 1'b0, pos: 1'b1};
      3'd3:    d = '{neg: 1'b1, pos: 1'b0};
      3'd4:    d = '{neg: 1'b1, pos: 1'b1};
      default: d = '{neg: 1'b0, pos: 1'b0};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/csc_step_timer.sv
module csc_step_timer
  import csc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              active,
  input  logic [CNT_W-1:0]  period_in,
  output logic [STEP_W-1:0] step,
  output logic              last_cycle,
  output logic              final_cycle
);
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= CNT_W'(1);
      cnt      <= '0;
      step     <= '0;
    end else if (load) begin
      period_q <= (period_in == '0) ? CNT_W'(1) : period_in;
      cnt      <= '0;
      step     <= '0;
    end else if (active) begin
      if (cnt == period_q - CNT_W'(1)) begin
        cnt  <= '0;
        step <= step + STEP_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign last_cycle  = active && (cnt == period_q - CNT_W'(1));
  assign final_cycle = last_cycle && (step == STEP_W'(NSTEP - 1));
endmodule

// File: rtl/csc_pattern.sv
module csc_pattern
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              last_cycle,
  input  logic              final_cycle,
  input  logic [STEP_W-1:0] step,
  output logic              drv_neg,
  output logic              drv_pos
);
  drive_t nxt;
  always_comb nxt = drive_for(step + STEP_W'(1));

  always_ff @(posedge clk) begin
    if (rst || final_cycle) begin
      drv_neg <= 1'b0;
      drv_pos <= 1'b0;
    end else if (load) begin
      drv_neg <= drive_for('0).neg;
      drv_pos <= drive_for('0).pos;
    end else if (last_cycle) begin
      drv_neg <= nxt.neg;
      drv_pos <= nxt.pos;
    end
  end
endmodule

// File: rtl/csc_compare.sv
module csc_compare
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              last_cycle,
  input  logic [STEP_W-1:0] step,
  input  logic              level,
  output logic [NSTEP-1:0]  captured,
  output logic              fail,
  output logic [STEP_W-1:0] first_fail_idx
);
  logic [NSTEP-1:0] hit;
  logic [NSTEP-1:0] bad;

  for (genvar i = 0; i < NSTEP; i++) begin : g_step
    assign hit[i] = last_cycle && (step == STEP_W'(i));
    assign bad[i] = hit[i] && CARE_MASK[i] && (level != EXP_LEVEL[i]);
    always_ff @(posedge clk) begin
      if (rst || load)  captured[i] <= 1'b0;
      else if (hit[i])  captured[i] <= level;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      fail           <= 1'b0;
      first_fail_idx <= NO_FAIL_IDX;
    end else if (|bad) begin
      fail <= 1'b1;
      if (!fail) first_fail_idx <= step;
    end
  end
endmodule

// File: rtl/comp_step_checker.sv
module comp_step_checker
  import csc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] period_cycles,
  input  logic             amp_level,
  output logic             drv_neg,
  output logic             drv_pos,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [2:0]       first_fail_idx,
  output logic [4:0]       captured
);
  logic              accept;
  logic              level_s;
  logic [STEP_W-1:0] step;
  logic              last_cycle;
  logic              final_cycle;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= 1'b0;
    end else if (final_cycle) begin
      busy <= 1'b0;
      done <= 1'b1;
    end
  end

  csc_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(amp_level), .q(level_s)
  );

  csc_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(accept), .active(busy),
    .period_in(period_cycles), .step(step),
    .last_cycle(last_cycle), .final_cycle(final_cycle)
  );

  csc_pattern u_pat (
    .clk(clk), .rst(rst), .load(accept), .last_cycle(last_cycle),
    .final_cycle(final_cycle), .step(step),
    .drv_neg(drv_neg), .drv_pos(drv_pos)
  );

  csc_compare u_cmp (
    .clk(clk), .rst(rst), .load(accept), .last_cycle(last_cycle),
    .step(step), .level(level_s), .captured(captured),
    .fail(fail), .first_fail_idx(first_fail_idx)
  );
endmodule

// File: rtl/csc_checker.sv
module csc_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       drv_neg,
  input logic       drv_pos,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic [2:0] first_fail_idx
);
  p_idle_drive_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!drv_neg && !drv_pos));

  p_first_step_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!drv_neg && !drv_pos));

  p_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  p_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  p_fail_idx_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (fail == (first_fail_idx != 3'd7)));

  p_idx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (fail && busy) |=> $stable(first_fail_idx));

  p_restart_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!fail && !done && busy));
endmodule

bind comp_step_checker csc_checker u_csc_checker (
  .clk(clk), .rst(rst), .start(start), .drv_neg(drv_neg), .drv_pos(drv_pos),
  .busy(busy), .done(done), .fail(fail), .first_fail_idx(first_fail_idx)
);

// File: tb/comp_step_checker_tb.sv
module comp_step_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int NVEC = 8;
  localparam logic [4:0] EXP_LEVEL = 5'b00110;
  localparam logic [4:0] CARE_MASK = 5'b11110;

  // {period, per-step amplifier level (bit k = step k)}
  localparam logic [20:0] VEC [NVEC] = '{
    {16'd3,  5'b00110}, {16'd4,  5'b00111}, {16'd5,  5'b00010},
    {16'd3,  5'b10110}, {16'd7,  5'b10100}, {16'd6,  5'b01110},
    {16'd4,  5'b00000}, {16'd10, 5'b00110}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] period_cycles = '0;
  logic amp_level = 1'b0;
  logic drv_neg, drv_pos, busy, done, fail;
  logic [2:0] first_fail_idx;
  logic [4:0] captured;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comp_step_checker #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .period_cycles(period_cycles),
    .amp_level(amp_level), .drv_neg(drv_neg), .drv_pos(drv_pos),
    .busy(busy), .done(done), .fail(fail),
    .first_fail_idx(first_fail_idx), .captured(captured)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_drive(input int k);
    case (k)
      1: return 2'b01;
      3: return 2'b10;
      4: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // One full run; poke_step >= 0 sends a start (ignored) at that step
  task automatic run(input int p, input logic [4:0] lv, input int poke_step);
    logic [4:0] bad;
    logic [2:0] idx;
    @(negedge clk);
    start = 1'b1;
    period_cycles = CNT_W'(p);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R9 fail cleared", fail, 0);
    check("R9 idx cleared", first_fail_idx, 7);
    for (int k = 0; k < 5; k++) begin
      amp_level = lv[k];
      check("R2 drive per step", {drv_neg, drv_pos}, exp_drive(k));
      check("R2 busy in step", busy, 1);
      if (k == poke_step) begin
        start = 1'b1;
        period_cycles = CNT_W'(p + 5);
      end
      for (int j = 0; j < p; j++) begin
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
      end
    end
    bad = (lv ^ EXP_LEVEL) & CARE_MASK;
    idx = 3'd7;
    for (int k = 4; k >= 0; k--) if (bad[k]) idx = 3'(k);
    check("R6 done", done, 1);
    check("R6 busy low", busy, 0);
    check("R6 drive idle", {drv_neg, drv_pos}, 0);
    check("R3 captured", captured, lv);
    check("R4 fail", fail, |bad);
    check("R5 first idx", first_fail_idx, idx);
    repeat (3) @(negedge clk);
    check("R6 results hold", {done, fail, first_fail_idx, captured}, {1'b1, |bad, idx, lv});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 drive", {drv_neg, drv_pos}, 0);
    check("R1 flags", {busy, done, fail}, 0);
    check("R1 idx", first_fail_idx, 7);
    check("R1 captured", captured, 0);

    for (int v = 0; v < NVEC; v++)
      run(int'(VEC[v][20:5]), VEC[v][4:0], -1);

    // R7: start during busy is ignored; timing stays at the first period
    run(4, 5'b10110, 2);
    run(3, 5'b00110, 4);

    // R8: zero period behaves as one clock per step
    @(negedge clk);
    start = 1'b1;
    period_cycles = '0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    begin
      int c;
      c = 0;
      while (!done && c < 50) begin
        @(posedge clk);
        @(negedge clk);
        c++;
      end
      check("R8 zero period length", c, 5);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule